// File: doc/BRIEF.md
# Tuning Completion and IF Validity Monitor

This block watches one tuning operation of a receiver (a channel search or a jump to a preset) and reports two facts to an interrupt controller. It reports that the operation has finished, and it reports whether the intermediate-frequency count has ever left its acceptance window. A tune start strobe opens the operation. In that tuning phase every valid count sample is compared against an inclusive window whose lower and upper limits are inputs. A tune done strobe ends the phase and raises the completion flag.

After completion the block ignores count samples for a fixed settling time, given as a cycle count. It then checks every valid sample for as long as the receiver stays on the channel. Any sample outside the window sets the sticky error flag. A status read clears both flags. A new tune start clears the error flag and aborts any settling or continuous checking in progress. Masking and interrupt generation are left to the interrupt controller that takes the flags.

Top module: `tune_monitor`

## Requirements
- R1: After reset both flags are 0 and the block is idle.
- R2: A tune start clears the IF error flag on the next clock, even if an out-of-window sample arrives in the same cycle, and enters the tuning phase.
- R3: In the tuning phase, a valid sample with count < low or count > high sets the IF error flag on the next clock. Counts equal to low or high are accepted.
- R4: A tune done in the tuning phase sets the completion flag on the next clock. A tune done in any other phase is ignored.
- R5: For the SETTLE_CYCLES clocks that follow an accepted tune done, count samples have no effect on the error flag.
- R6: Once settling is over, every valid sample is checked against the window until the next tune start.
- R7: A status read clears both flags on the next clock. A flag that is being set in the same cycle stays set.
- R8: A tune start during settling or continuous checking aborts it and returns to the tuning phase. A later tune done restarts the full settling time.
- R9: Samples without the valid strobe, and any sample while idle, are ignored.
- R10: Both flags hold their value until they are cleared by R2 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tuneStart | input | 1 | One-cycle strobe: a search or preset begins |
| tuneDone | input | 1 | One-cycle strobe: the search or preset ended |
| ifCount | input | CNT_W | IF count sample |
| ifValid | input | 1 | ifCount holds a fresh sample |
| winLow | input | CNT_W | Inclusive lower window limit |
| winHigh | input | CNT_W | Inclusive upper window limit |
| statusRead | input | 1 | One-cycle strobe: the status register was read |
| doneFlag | output | 1 | Tuning operation completed |
| ifErrFlag | output | 1 | An IF count outside the window was seen |

## Verification
The assertions assume that the strobes are single-cycle pulses that are synchronous to clk. They also assume that the window limits stay steady while samples are being checked, so that a flag change can be traced to one sample. The stimulus changes inputs only on the falling edge and holds winLow and winHigh fixed throughout the run. It pulses each strobe for one cycle, including the cases where a start, a read or a done coincides with a sample. A settling time of 8 cycles keeps the boundary between the ignored and the checked sample inside a short run.

// File: rtl/tune_monitor_pkg.sv
package tune_monitor_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_TUNING  = 2'd1,
    PH_SETTLE  = 2'd2,
    PH_MONITOR = 2'd3
  } phaseT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic checkEn;  // current sample must be judged
    logic setDone;  // operation completed this cycle
    logic clrErr;   // new operation: drop the error flag
  } ctlT;

endpackage

// File: rtl/tune_monitor_ctrl.sv
module tune_monitor_ctrl
  import tune_monitor_pkg::*;
#(
  parameter int SETTLE_CYCLES = 750000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tuneStart,
  input  logic tuneDone,
  output ctlT  ctl
);

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  phaseT               phase;
  logic [SETTLE_W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      settleCnt <= '0;
    end else if (tuneStart) begin
      phase     <= PH_TUNING;
      settleCnt <= '0;
    end else begin
      case (phase)
        PH_TUNING: begin
          if (tuneDone) begin
            phase     <= PH_SETTLE;
            settleCnt <= SETTLE_W'(SETTLE_CYCLES - 1);
          end
        end
        PH_SETTLE: begin
          if (settleCnt == '0) phase <= PH_MONITOR;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.clrErr  = tuneStart;
    ctl.setDone = (phase == PH_TUNING) && tuneDone && !tuneStart;
    ctl.checkEn = ((phase == PH_TUNING) || (phase == PH_MONITOR)) && !tuneStart;
  end

  // R4: a done strobe outside a tuning operation leaves the block idle
  assert_idle_ignores_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !tuneStart) |=> (phase == PH_IDLE));

  // R5: settling only ever moves on to continuous checking
  assert_settle_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETTLE && !tuneStart) |=> (phase == PH_SETTLE || phase == PH_MONITOR));

  // R8: a start always lands in the tuning phase
  assert_start_aborts_R8: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |=> (phase == PH_TUNING));

endmodule

// File: rtl/tune_monitor_dp.sv
module tune_monitor_dp
  import tune_monitor_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlT              ctl,
  input  logic [CNT_W-1:0] ifCount,
  input  logic             ifValid,
  input  logic [CNT_W-1:0] winLow,
  input  logic [CNT_W-1:0] winHigh,
  input  logic             statusRead,
  output logic             doneFlag,
  output logic             ifErrFlag
);

  logic outOfWindow;
  logic badSample;

  assign outOfWindow = (ifCount < winLow) || (ifCount > winHigh);
  assign badSample   = ctl.checkEn && ifValid && outOfWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifErrFlag <= 1'b0;
    end else if (ctl.clrErr) begin
      ifErrFlag <= 1'b0;
    end else if (badSample) begin
      ifErrFlag <= 1'b1;
    end else if (statusRead) begin
      ifErrFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (ctl.setDone) begin
      doneFlag <= 1'b1;
    end else if (statusRead) begin
      doneFlag <= 1'b0;
    end
  end

  // R2: a new operation always starts with a clean error flag
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrErr |=> !ifErrFlag);

  // R4: completion is reported on the next clock
  assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setDone |=> doneFlag);

  // R7: a read without a fresh completion drops the completion flag
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !ctl.setDone) |=> !doneFlag);

  // R10: the error flag is sticky until a read or a start
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ifErrFlag && !statusRead && !ctl.clrErr) |=> ifErrFlag);

  // R10: the completion flag is sticky until a read
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !statusRead) |=> doneFlag);

endmodule

// File: rtl/tune_monitor.sv
module tune_monitor
  import tune_monitor_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 750000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tuneStart,
  input  logic             tuneDone,
  input  logic [CNT_W-1:0] ifCount,
  input  logic             ifValid,
  input  logic [CNT_W-1:0] winLow,
  input  logic [CNT_W-1:0] winHigh,
  input  logic             statusRead,
  output logic             doneFlag,
  output logic             ifErrFlag
);

  ctlT ctl;

  tune_monitor_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tuneStart(tuneStart),
    .tuneDone (tuneDone),
    .ctl      (ctl)
  );

  tune_monitor_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ifCount   (ifCount),
    .ifValid   (ifValid),
    .winLow    (winLow),
    .winHigh   (winHigh),
    .statusRead(statusRead),
    .doneFlag  (doneFlag),
    .ifErrFlag (ifErrFlag)
  );

  // R1: flags come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!doneFlag && !ifErrFlag));

endmodule

// File: tb/tune_monitor_bench.sv
`timescale 1ns/1ps
module tune_monitor_bench;

  localparam int CNT_W  = 8;
  localparam int SETTLE = 8;
  localparam logic [CNT_W-1:0] LO = 8'd100;
  localparam logic [CNT_W-1:0] HI = 8'd140;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tuneStart = 1'b0;
  logic             tuneDone = 1'b0;
  logic [CNT_W-1:0] ifCount = '0;
  logic             ifValid = 1'b0;
  logic             statusRead = 1'b0;
  logic             doneFlag;
  logic             ifErrFlag;

  always #10 clk = ~clk;  // 50 MHz

  tune_monitor #(
    .CNT_W(CNT_W),
    .SETTLE_CYCLES(SETTLE)
  ) u_tune_monitor (
    .clk       (clk),
    .rstN      (rstN),
    .tuneStart (tuneStart),
    .tuneDone  (tuneDone),
    .ifCount   (ifCount),
    .ifValid   (ifValid),
    .winLow    (LO),
    .winHigh   (HI),
    .statusRead(statusRead),
    .doneFlag  (doneFlag),
    .ifErrFlag (ifErrFlag)
  );

  typedef struct {
    logic  expDone;
    logic  expErr;
    string req;
  } expT;

  expT queueExp[$];
  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  // reference model state, written from the requirements
  int   mPhase  = 0;  // 0 idle, 1 tuning, 2 settling, 3 checking
  int   mIgnore = 0;
  logic mDone   = 1'b0;
  logic mErr    = 1'b0;

  task automatic step(input logic st, input logic dn, input logic vl,
                      input logic [CNT_W-1:0] cnt, input logic rd, input string req);
    logic chk, outside, setD;
    expT  e;
    @(negedge clk);
    tuneStart  = st;
    tuneDone   = dn;
    ifValid    = vl;
    ifCount    = cnt;
    statusRead = rd;
    outside = (cnt < LO) || (cnt > HI);
    chk  = !st && vl && outside && (mPhase == 1 || mPhase == 3);
    setD = !st && dn && (mPhase == 1);
    if (st) begin
      mPhase = 1;
    end else if (mPhase == 1 && dn) begin
      mPhase = 2; mIgnore = SETTLE;
    end else if (mPhase == 2) begin
      mIgnore--;
      if (mIgnore == 0) mPhase = 3;
    end
    if (st)       mErr = 1'b0;
    else if (chk) mErr = 1'b1;
    else if (rd)  mErr = 1'b0;
    if (setD)     mDone = 1'b1;
    else if (rd)  mDone = 1'b0;
    @(posedge clk);
    #1;
    e.expDone = mDone;
    e.expErr  = mErr;
    e.req     = req;
    queueExp.push_back(e);
  endtask

  // monitor: compares each result half a cycle after it is produced
  initial begin
    forever begin
      @(negedge clk);
      if (queueExp.size() > 0) begin
        expT e;
        e = queueExp.pop_front();
        total++;
        if (doneFlag !== e.expDone || ifErrFlag !== e.expErr) begin
          bad++;
          $display("FAIL %s: done=%b err=%b expected done=%b err=%b",
                   e.req, doneFlag, ifErrFlag, e.expDone, e.expErr);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, idle
    step(0, 0, 0, 8'd120, 0, "R1");
    step(0, 0, 0, 8'd120, 0, "R1");
    // R9: idle ignores bad samples
    step(0, 0, 1, 8'd10, 0, "R9");
    // R4: done while idle ignored
    step(0, 1, 0, 8'd120, 0, "R4");
    // R2: start
    step(1, 0, 0, 8'd120, 0, "R2");
    // R3: window limits inclusive
    step(0, 0, 1, 8'd100, 0, "R3");
    step(0, 0, 1, 8'd140, 0, "R3");
    // R9: invalid strobe ignored
    step(0, 0, 0, 8'd5, 0, "R9");
    // R3: below window
    step(0, 0, 1, 8'd99, 0, "R3");
    // R10: sticky
    step(0, 0, 1, 8'd120, 0, "R10");
    // R7: read clears
    step(0, 0, 0, 8'd120, 1, "R7");
    // R3: above window
    step(0, 0, 1, 8'd141, 0, "R3");
    // R2: start clears
    step(1, 0, 0, 8'd120, 0, "R2");
    step(0, 0, 1, 8'd200, 0, "R3");
    // R2: start wins over coincident bad sample
    step(1, 0, 1, 8'd0, 0, "R2");
    // R4: done sets completion
    step(0, 1, 0, 8'd120, 0, "R4");
    // R5: settling window ignores bad samples
    for (int i = 0; i < SETTLE; i++) step(0, 0, 1, 8'd250, 0, "R5");
    // R6: first checked sample
    step(0, 0, 1, 8'd250, 0, "R6");
    step(0, 0, 1, 8'd120, 1, "R7");
    step(0, 0, 1, 8'd120, 0, "R6");
    step(0, 0, 0, 8'd120, 0, "R6");
    // R7: read coinciding with bad sample keeps error
    step(0, 0, 1, 8'd20, 1, "R7");
    step(0, 0, 0, 8'd120, 1, "R7");
    // R4: done during checking ignored
    step(0, 1, 0, 8'd120, 0, "R4");
    // R8: abort during settling
    step(1, 0, 0, 8'd120, 0, "R8");
    step(0, 1, 0, 8'd120, 0, "R4");
    step(0, 0, 0, 8'd120, 1, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 8'd250, 0, "R5");
    step(1, 0, 0, 8'd120, 0, "R8");
    step(0, 0, 1, 8'd250, 0, "R8");
    step(0, 0, 0, 8'd120, 1, "R7");
    // R7: done and read together keep completion set
    step(0, 1, 0, 8'd120, 1, "R7");
    // R8: full settling restarts
    for (int i = 0; i < SETTLE; i++) step(0, 0, 1, 8'd1, 0, "R8");
    step(0, 0, 1, 8'd1, 0, "R6");
    // R10: both flags hold
    step(0, 0, 0, 8'd120, 0, "R10");
    step(0, 0, 0, 8'd120, 1, "R7");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule